// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Requests

This block keeps the status flags of a byte-wide, double-buffered SPI peripheral and turns them into interrupt requests. It sits between the decoded CPU register accesses and the serial shift core. The shift core reports each completed byte, each hand-off from the transmit buffer and whether a transfer is running. The block holds the receive data register and the transmit data buffer, so it can keep an unread byte when an overflow occurs and can ignore a data write that arrives too early.

The receive-full, overflow and mode-fault flags are sticky. Each one clears only through its own two-step access: first a status read that sees the flag set, then a second access. For receive-full and overflow the second access is a data read. For mode fault it is a control write. If a new event sets the flag in the same cycle as the second access, the flag stays set, so no event is lost. Mode fault is detected from the slave-select pin level, and the rule depends on the mode. The transmit-empty flag tracks whether the transmit buffer is free.

Top module: `spi_flag_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after reset, rx_full, overflow and mode_fault are 0, tx_empty is 1, and all three interrupt outputs follow from these values.
- R2: When rx_done is high and rx_full is 0, rd_byte takes the value of rx_byte and rx_full reads 1 in the next cycle.
- R3: rx_full clears only when a data read (rd_data) follows an earlier status read (rd_status) that saw rx_full at 1. A data read with no such armed status read leaves rx_full at 1.
- R4: A byte that completes while rx_full is 1, and rx_full is not being cleared in that cycle, sets overflow in the next cycle. The new byte is discarded and rd_byte keeps its value.
- R5: overflow clears when a data read follows a status read that saw overflow at 1. A data read with no such armed status read leaves overflow at 1.
- R6: In slave mode (master_mode=0) with modf_en=1, mode_fault sets when ss_level is 1 while xfer_active is 1. It does not set when xfer_active is 0 or when modf_en is 0.
- R7: In master mode (master_mode=1) with modf_en=1, mode_fault sets whenever ss_level is 0.
- R8: mode_fault clears when a control write (wr_ctrl) follows a status read that saw mode_fault at 1. If the fault condition still holds in the cycle of the write, the flag stays set.
- R9: irq_rx is rx_full AND rx_ie. irq_err is err_ie AND (overflow OR mode_fault). irq_tx is tx_empty AND tx_ie.
- R10: A data write (wr_data) while tx_empty is 1 stores wr_wdata on tx_byte and drives tx_empty to 0 in the next cycle. tx_take while tx_empty is 0 sets tx_empty in the next cycle.
- R11: A data write while tx_empty is 0 is ignored: tx_byte and tx_empty stay unchanged.
- R12: If a new setting event arrives in the same cycle as the clearing second access, the flag stays 1 and the arm is dropped. For a received byte this means the new byte is loaded into rd_byte and overflow does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | Strobe: shift core completed a received byte |
| rx_byte | input | DW | Byte completed by the shift core |
| tx_take | input | 1 | Strobe: shift core loads the transmit buffer byte |
| xfer_active | input | 1 | A transfer is in progress |
| ss_level | input | 1 | Slave-select pin level (1 = inactive) |
| master_mode | input | 1 | 1 = master, 0 = slave |
| modf_en | input | 1 | Mode-fault detection enable |
| rd_status | input | 1 | Decoded status register read strobe |
| rd_data | input | 1 | Decoded data register read strobe |
| wr_ctrl | input | 1 | Decoded control register write strobe |
| wr_data | input | 1 | Decoded data register write strobe |
| wr_wdata | input | DW | Write data for the transmit buffer |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_full | output | 1 | Receive data register holds an unread byte |
| overflow | output | 1 | A received byte was dropped |
| mode_fault | output | 1 | Slave select seen at a wrong level |
| tx_empty | output | 1 | Transmit buffer is free |
| rd_byte | output | DW | Receive data register contents |
| tx_byte | output | DW | Transmit buffer contents for the shift core |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The assertions check the single-cycle rules on every cycle. These are: a byte arriving in an empty register sets receive-full, an overflow never changes the held byte, a master-mode fault sets the flag, a hand-off empties the buffer, an early data write leaves the buffer unchanged, a sticky flag never drops without its second access in the previous cycle, and the error request is never raised without a flag behind it. The two-step clear sequences need a status read followed later by a data read or control write. Other cases also need a sequence of cycles: an unarmed access that has no effect, a slave-select pulse outside a transfer, and an event that lands on the clearing access. Only the bench scenarios show these, by comparing every output each cycle against a model that is driven by random bus traffic.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    localparam int NFLAG  = 3;
    localparam int FI_RXF = 0;
    localparam int FI_OVR = 1;
    localparam int FI_MDF = 2;

    typedef struct packed {
        logic rx;
        logic err;
        logic tx;
    } irq_vec_t;

    typedef struct packed {
        logic rxf;
        logic ovr;
        logic mdf;
        logic txe;
    } flag_vec_t;

    // Slave-select level check: master faults on any low level, slave faults
    // when deselected mid-transfer.
    function automatic logic modf_hit(input logic is_master, input logic en,
                                      input logic ss, input logic busy);
        logic hit;
        if (is_master) hit = ~ss;
        else           hit = ss & busy;
        return en & hit;
    endfunction

    function automatic irq_vec_t irq_gate(input flag_vec_t f, input irq_vec_t en);
        irq_vec_t r;
        r.rx  = f.rxf & en.rx;
        r.err = (f.ovr | f.mdf) & en.err;
        r.tx  = f.txe & en.tx;
        return r;
    endfunction

endpackage

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic arm_req,
    input  logic fin_acc,
    output logic flag_q,
    output logic arm_q
);
    logic do_clear;

    assign do_clear = fin_acc & arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= set_evt | (flag_q & ~do_clear);
            if (fin_acc)
                arm_q <= 1'b0;
            else if (arm_req & flag_q)
                arm_q <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_byte,
    input  logic          full_now,
    input  logic          clr_now,
    output logic [DW-1:0] hold_q,
    output logic          full_set,
    output logic          ovr_set
);
    logic slot_free;

    assign slot_free = ~full_now | clr_now;
    assign full_set  = rx_done;
    assign ovr_set   = rx_done & ~slot_free;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (rx_done & slot_free)
            hold_q <= rx_byte;
    end
endmodule

// File: rtl/spi_tx_buffer.sv
module spi_tx_buffer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_data,
    input  logic [DW-1:0] wr_wdata,
    input  logic          tx_take,
    output logic          empty_q,
    output logic [DW-1:0] buf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            buf_q   <= '0;
        end else if (tx_take & ~empty_q) begin
            empty_q <= 1'b1;
        end else if (wr_data & empty_q) begin
            buf_q   <= wr_wdata;
            empty_q <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_byte,
    input  logic          tx_take,
    input  logic          xfer_active,
    input  logic          ss_level,
    input  logic          master_mode,
    input  logic          modf_en,
    input  logic          rd_status,
    input  logic          rd_data,
    input  logic          wr_ctrl,
    input  logic          wr_data,
    input  logic [DW-1:0] wr_wdata,
    input  logic          rx_ie,
    input  logic          err_ie,
    input  logic          tx_ie,
    output logic          rx_full,
    output logic          overflow,
    output logic          mode_fault,
    output logic          tx_empty,
    output logic [DW-1:0] rd_byte,
    output logic [DW-1:0] tx_byte,
    output logic          irq_rx,
    output logic          irq_err,
    output logic          irq_tx
);
    logic [NFLAG-1:0] f_set, f_arm_req, f_fin, f_q, f_arm;
    logic             rx_clr, rxf_set, ovr_set;
    flag_vec_t        fv;
    irq_vec_t         en_v, irq_v;

    assign rx_clr = rd_data & f_arm[FI_RXF];

    spi_rx_hold #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .full_now (f_q[FI_RXF]),
        .clr_now  (rx_clr),
        .hold_q   (rd_byte),
        .full_set (rxf_set),
        .ovr_set  (ovr_set)
    );

    spi_tx_buffer #(.DW(DW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr_data  (wr_data),
        .wr_wdata (wr_wdata),
        .tx_take  (tx_take),
        .empty_q  (tx_empty),
        .buf_q    (tx_byte)
    );

    always_comb begin
        f_set            = '0;
        f_fin            = '0;
        f_set[FI_RXF]    = rxf_set;
        f_set[FI_OVR]    = ovr_set;
        f_set[FI_MDF]    = modf_hit(master_mode, modf_en, ss_level, xfer_active);
        f_fin[FI_RXF]    = rd_data;
        f_fin[FI_OVR]    = rd_data;
        f_fin[FI_MDF]    = wr_ctrl;
        f_arm_req        = {NFLAG{rd_status}};
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        spi_sticky_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_evt (f_set[g]),
            .arm_req (f_arm_req[g]),
            .fin_acc (f_fin[g]),
            .flag_q  (f_q[g]),
            .arm_q   (f_arm[g])
        );
    end

    assign rx_full    = f_q[FI_RXF];
    assign overflow   = f_q[FI_OVR];
    assign mode_fault = f_q[FI_MDF];

    assign fv    = '{rxf: rx_full, ovr: overflow, mdf: mode_fault, txe: tx_empty};
    assign en_v  = '{rx: rx_ie, err: err_ie, tx: tx_ie};
    assign irq_v = irq_gate(fv, en_v);

    assign irq_rx  = irq_v.rx;
    assign irq_err = irq_v.err;
    assign irq_tx  = irq_v.tx;
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_done,
    input logic          tx_take,
    input logic          master_mode,
    input logic          modf_en,
    input logic          ss_level,
    input logic          rd_data,
    input logic          wr_ctrl,
    input logic          wr_data,
    input logic          rx_full,
    input logic          overflow,
    input logic          mode_fault,
    input logic          tx_empty,
    input logic [DW-1:0] rd_byte,
    input logic [DW-1:0] tx_byte,
    input logic          irq_err
);
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!rx_full && !overflow && !mode_fault && tx_empty));

    a_r2_rx_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rx_full) |=> rx_full);

    a_r3_rxf_needs_read: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_full) |-> $past(rd_data));

    a_r4_ovr_keeps_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $stable(rd_byte));

    a_r5_ovr_needs_read: assert property (@(posedge clk) disable iff (rst)
        $fell(overflow) |-> $past(rd_data));

    a_r7_master_fault: assert property (@(posedge clk) disable iff (rst)
        (modf_en && master_mode && !ss_level) |=> mode_fault);

    a_r8_mdf_needs_write: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_fault) |-> $past(wr_ctrl));

    a_r9_err_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> (overflow || mode_fault));

    a_r10_take_empties: assert property (@(posedge clk) disable iff (rst)
        (tx_take && !tx_empty) |=> tx_empty);

    a_r11_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !tx_empty) |=> $stable(tx_byte));
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_done     (rx_done),
    .tx_take     (tx_take),
    .master_mode (master_mode),
    .modf_en     (modf_en),
    .ss_level    (ss_level),
    .rd_data     (rd_data),
    .wr_ctrl     (wr_ctrl),
    .wr_data     (wr_data),
    .rx_full     (rx_full),
    .overflow    (overflow),
    .mode_fault  (mode_fault),
    .tx_empty    (tx_empty),
    .rd_byte     (rd_byte),
    .tx_byte     (tx_byte),
    .irq_err     (irq_err)
);

// File: tb/spi_flag_ctrl_test.sv
`timescale 1ns/1ps
module spi_flag_ctrl_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          rx_done, tx_take, xfer_active, ss_level, master_mode, modf_en;
    logic          rd_status, rd_data, wr_ctrl, wr_data, rx_ie, err_ie, tx_ie;
    logic [DW-1:0] rx_byte, wr_wdata;
    logic          rx_full, overflow, mode_fault, tx_empty, irq_rx, irq_err, irq_tx;
    logic [DW-1:0] rd_byte, tx_byte;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic          m_rxf, m_rxa, m_ovr, m_ova, m_mdf, m_mda, m_txe;
    logic [DW-1:0] m_rxd, m_txd;

    always #2 clk = ~clk;

    spi_flag_ctrl #(.DW(DW)) uut (.*);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic quiet();
        rx_done = 0; tx_take = 0; rd_status = 0; rd_data = 0; wr_ctrl = 0; wr_data = 0;
        rx_byte = '0; wr_wdata = '0;
    endtask

    task automatic model_reset();
        m_rxf = 0; m_rxa = 0; m_ovr = 0; m_ova = 0; m_mdf = 0; m_mda = 0;
        m_txe = 1; m_rxd = '0; m_txd = '0;
    endtask

    // next-state of the expected flags, from the requirement text
    task automatic model_step();
        logic rxclr, ovclr, mdclr, fault;
        rxclr = rd_data & m_rxa;
        ovclr = rd_data & m_ova;
        mdclr = wr_ctrl & m_mda;
        fault = modf_en & (master_mode ? ~ss_level : (ss_level & xfer_active));
        if (rx_done && (!m_rxf || rxclr)) m_rxd = rx_byte;
        m_ovr = (rx_done & m_rxf & ~rxclr) | (m_ovr & ~ovclr);
        m_rxf = rx_done | (m_rxf & ~rxclr);
        m_mdf = fault | (m_mdf & ~mdclr);
        m_rxa = rd_data ? 1'b0 : ((rd_status & uut.rx_full) ? 1'b1 : m_rxa);
        m_ova = rd_data ? 1'b0 : ((rd_status & uut.overflow) ? 1'b1 : m_ova);
        m_mda = wr_ctrl ? 1'b0 : ((rd_status & uut.mode_fault) ? 1'b1 : m_mda);
        if (tx_take && !m_txe) m_txe = 1;
        else if (wr_data && m_txe) begin m_txd = wr_wdata; m_txe = 0; end
    endtask

    task automatic compare();
        chk(rx_full == m_rxf,   "R2 rx_full",    rx_full,    m_rxf);
        chk(rd_byte == m_rxd,   "R4 rd_byte",    rd_byte,    m_rxd);
        chk(overflow == m_ovr,  "R5 overflow",   overflow,   m_ovr);
        chk(mode_fault == m_mdf,"R6 mode_fault", mode_fault, m_mdf);
        chk(tx_empty == m_txe,  "R10 tx_empty",  tx_empty,   m_txe);
        chk(tx_byte == m_txd,   "R11 tx_byte",   tx_byte,    m_txd);
        chk(irq_rx == (m_rxf & rx_ie), "R9 irq_rx", irq_rx, m_rxf & rx_ie);
        chk(irq_err == ((m_ovr | m_mdf) & err_ie), "R9 irq_err", irq_err, (m_ovr | m_mdf) & err_ie);
        chk(irq_tx == (m_txe & tx_ie), "R9 irq_tx", irq_tx, m_txe & tx_ie);
    endtask

    // inputs are held; model uses pre-edge DUT flags for arm logic
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare();
        quiet();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        quiet();
        xfer_active = 0; ss_level = 1; master_mode = 0; modf_en = 1;
        rx_ie = 1; err_ie = 1; tx_ie = 1;
        rst = 1;
        model_reset();
        @(posedge clk); @(posedge clk); #1;
        chk(!rx_full && !overflow && !mode_fault && tx_empty, "R1 reset flags",
            {rx_full, overflow, mode_fault, tx_empty}, 4'b0001);
        rst = 0;
        cyc();
        chk(!rx_full && tx_empty && irq_tx && !irq_rx, "R1 after reset",
            {rx_full, tx_empty, irq_tx, irq_rx}, 4'b0110);

        // R2: receive a byte
        rx_done = 1; rx_byte = 8'h5A; cyc();
        chk(rx_full && rd_byte == 8'h5A, "R2 byte loaded", rd_byte, 8'h5A);
        // R3: unarmed data read leaves the flag
        rd_data = 1; cyc();
        chk(rx_full == 1, "R3 unarmed read", rx_full, 1);
        // R4: second byte overflows, old byte kept
        rx_done = 1; rx_byte = 8'hC3; cyc();
        chk(overflow && rd_byte == 8'h5A, "R4 old byte kept", rd_byte, 8'h5A);
        // R5 and R3: status read then data read clears both
        rd_status = 1; cyc();
        rd_data = 1; cyc();
        chk(!rx_full && !overflow, "R5 two-step clear", {rx_full, overflow}, 2'b00);

        // R12: event in the same cycle as the clearing read
        rx_done = 1; rx_byte = 8'h11; cyc();
        rd_status = 1; cyc();
        rd_data = 1; rx_done = 1; rx_byte = 8'h22; cyc();
        chk(rx_full && !overflow && rd_byte == 8'h22, "R12 same-cycle rx",
            rd_byte, 8'h22);
        rd_data = 1; cyc();
        chk(rx_full == 1, "R12 arm dropped", rx_full, 1);
        rd_status = 1; cyc(); rd_data = 1; cyc();

        // R6: slave fault only during a transfer
        ss_level = 1; xfer_active = 0; cyc();
        chk(mode_fault == 0, "R6 idle ss high", mode_fault, 0);
        modf_en = 0; xfer_active = 1; cyc();
        chk(mode_fault == 0, "R6 detection off", mode_fault, 0);
        modf_en = 1; cyc(); xfer_active = 0;
        chk(mode_fault == 1, "R6 slave fault", mode_fault, 1);
        // R8 and R12: clear while fault persists stays set
        rd_status = 1; cyc();
        xfer_active = 1; wr_ctrl = 1; cyc();
        chk(mode_fault == 1, "R12 modf persists", mode_fault, 1);
        xfer_active = 0; rd_status = 1; cyc();
        wr_ctrl = 1; cyc();
        chk(mode_fault == 0, "R8 modf cleared", mode_fault, 0);
        // R7: master faults on low select
        master_mode = 1; ss_level = 0; cyc();
        chk(mode_fault == 1 && irq_err, "R7 master fault", mode_fault, 1);
        ss_level = 1; rd_status = 1; cyc(); wr_ctrl = 1; cyc();
        chk(mode_fault == 0, "R8 master clear", mode_fault, 0);
        master_mode = 0;

        // R10 and R11: transmit buffer
        wr_data = 1; wr_wdata = 8'hA5; cyc();
        chk(!tx_empty && tx_byte == 8'hA5, "R10 buffer loaded", tx_byte, 8'hA5);
        wr_data = 1; wr_wdata = 8'h3C; cyc();
        chk(!tx_empty && tx_byte == 8'hA5, "R11 busy write ignored", tx_byte, 8'hA5);
        tx_take = 1; cyc();
        chk(tx_empty == 1, "R10 take empties", tx_empty, 1);
        // R9: enables off mask requests
        rx_ie = 0; tx_ie = 0; err_ie = 0; rx_done = 1; rx_byte = 8'h01; cyc();
        chk(!irq_rx && !irq_tx && !irq_err, "R9 masked", {irq_rx, irq_tx, irq_err}, 0);
        rd_status = 1; cyc(); rd_data = 1; cyc();

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            rx_done     = ($urandom % 6) == 0;
            rx_byte     = DW'($urandom);
            tx_take     = ($urandom % 5) == 0;
            wr_data     = ($urandom % 4) == 0;
            wr_wdata    = DW'($urandom);
            rd_status   = ($urandom % 4) == 0;
            rd_data     = !rd_status && (($urandom % 4) == 0);
            wr_ctrl     = !rd_status && !rd_data && (($urandom % 8) == 0);
            xfer_active = ($urandom % 3) != 0;
            if ((i % 200) == 0) master_mode = $urandom % 2;
            ss_level    = ($urandom % 10) != 0;
            modf_en     = ($urandom % 8) != 0;
            rx_ie       = $urandom % 2;
            err_ie      = $urandom % 2;
            tx_ie       = $urandom % 2;
            cyc();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule